// File: doc/BRIEF.md
# Observe-Only Boundary-Scan Test Port

This block is a serial test access port for a memory device. It follows the usual four-wire scan convention: a sixteen-state controller stepped by a test clock and a mode pin, a serial input, a serial output and an optional asynchronous test reset. Through it a board tester can read a fixed identification word, skip the device with a one-bit bypass path, or take a snapshot of the device's pin vector and shift it out. The pins can be observed but never driven.

It is deliberately not a full implementation of the standard. The all-zeros instruction and the sample-with-tristate instruction both capture the pins exactly as the plain sample instruction does. They also raise a request that puts the data pins into high impedance for as long as either is the active instruction. Update-DR never loads anything toward the pins. The serial port is a plain bit-serial control interface, not a stream: it has no valid/ready handshake and no back-pressure. Every rising test-clock edge advances the controller and moves one bit.

Top module: `scan_tap`

## Requirements
- R1: While the test reset is low, and at any time the controller sits in Test-Logic-Reset, the active instruction is IDCODE (code 001), the high-Z request is low and the output enable is low.
- R2: Five consecutive rising test-clock edges with the mode pin high bring the controller to Test-Logic-Reset from any state.
- R3: In Capture-IR the 3-bit instruction shift register loads 001, so its two low bits hold 01. In Shift-IR it moves one place toward bit 0 per edge, takes the serial input into bit 2 and presents bit 0 on the serial output.
- R4: A shifted instruction becomes active only on the edge that leaves Update-IR. The high-Z request keeps its old value through Shift-IR, Exit1-IR and Update-IR.
- R5: Under IDCODE, Capture-DR loads the 32-bit ID parameter, and Shift-DR sends it out bit 0 first.
- R6: Under BYPASS (code 111), Capture-DR loads 0 into the one-bit bypass register. The serial output therefore shows 0 first and then the serial input delayed by one shift.
- R7: Under SAMPLE (code 100), Capture-DR copies the pin vector into the boundary register, and Shift-DR sends it out bit 0 first. The high-Z request stays low.
- R8: Update-DR has no effect. The high-Z request does not change, and the next Capture-DR returns the current pins, not the bits that were shifted in.
- R9: Under the all-zeros instruction (code 000), the boundary register captures and shifts as under SAMPLE, and the high-Z request stays high while the instruction is active.
- R10: Under SAMPLE-Z (code 010), the high-Z request is high and Shift-DR uses the boundary register.
- R11: The reserved codes 011, 101 and 110 select the bypass register and leave the high-Z request low.
- R12: The serial output and its enable change on the falling test-clock edge. The enable is high exactly while the controller is in Shift-IR or Shift-DR, and the serial output is 0 whenever the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pins_in | input | BSR_W | Pin vector observed by the boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Serial output drive enable |
| dq_hiz | output | 1 | Request to place the data pins in high impedance |

## Verification
Two things can land on the same rising edge: the final shift of a register and the controller leaving the shift state, because the last serial bit is taken on the same edge that has the mode pin high. Every scan in the bench ends this way. A scoreboard counts exactly one output bit per falling edge in a shift state, so a dropped or extra final shift is caught. The instruction loaded by such a final edge is then judged by its effect on the high-Z request and on which register the next data scan returns. A second same-cycle case is a change of the pin vector just before Capture-DR: the capture must return the new pins and not the bits that the previous Update-DR passed through.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_ALLZ   = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] { DR_BYP, DR_ID, DR_BSR } dr_sel_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st
);
  tap_state_e nx;

  always_comb begin
    unique case (st)
      ST_TLR:    nx = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nx = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nx = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nx = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nx = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nx = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nx = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nx = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nx = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nx = tms ? ST_SEL_DR : ST_RTI;
      default:   nx = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= nx;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_act
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh  <= IR_CAPTURE;
      ir_act <= OP_IDCODE;
    end else begin
      if (st == ST_CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (st == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (st == ST_TLR)        ir_act <= OP_IDCODE;
      else if (st == ST_UPD_IR) ir_act <= ir_sh;
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W  = 16,
  parameter int          ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1A5C_30E9
) (
  input  logic             tck,
  input  logic             trst_n,
  input  tap_state_e       st,
  input  dr_sel_e          sel,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pins_in,
  output logic             dr_lsb
);
  logic             byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_W-1:0] bsr_q;

  wire cap = (st == ST_CAP_DR);
  wire sh  = (st == ST_SH_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else begin
      unique case (sel)
        DR_ID: begin
          if (cap)     id_q <= ID_VAL;
          else if (sh) id_q <= {tdi, id_q[ID_W-1:1]};
        end
        DR_BSR: begin
          if (cap)     bsr_q <= pins_in;
          else if (sh) bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
        end
        default: begin
          if (cap)     byp_q <= 1'b0;
          else if (sh) byp_q <= tdi;
        end
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      DR_ID:   dr_lsb = id_q[0];
      DR_BSR:  dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q;
    endcase
  end
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              BSR_W  = 16,
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1A5C_30E9
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pins_in,
  output logic             tdo,
  output logic             tdo_en,
  output logic             dq_hiz
);
  tap_state_e      st;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_act;
  dr_sel_e         sel;
  logic            dr_lsb;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .st(st), .tdi(tdi), .ir_sh(ir_sh), .ir_act(ir_act)
  );

  always_comb begin
    unique case (ir_act)
      OP_IDCODE:                      sel = DR_ID;
      OP_ALLZ, OP_SAMPZ, OP_SAMPLE:   sel = DR_BSR;
      default:                        sel = DR_BYP;
    endcase
  end

  assign dq_hiz = (ir_act == OP_ALLZ) || (ir_act == OP_SAMPZ);

  tap_dr #(.BSR_W(BSR_W), .ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .st(st), .sel(sel), .tdi(tdi),
    .pins_in(pins_in), .dr_lsb(dr_lsb)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
      if (st == ST_SH_IR)      tdo <= ir_sh[0];
      else if (st == ST_SH_DR) tdo <= dr_lsb;
      else                     tdo <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_tap_sva.sv
module scan_tap_sva
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      st,
  input logic [IR_W-1:0] ir_sh,
  input logic [IR_W-1:0] ir_act,
  input logic            tdo,
  input logic            tdo_en,
  input logic            dq_hiz
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  ones <= '0;
    else if (!tms) ones <= '0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (st == ST_TLR));

  a_r1_tlr_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |=> (ir_act == OP_IDCODE));

  a_r3_capture_ir: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

  a_r4_ir_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_UPD_IR && st != ST_TLR) |=> $stable(ir_act));

  a_r4_hiz_rises_on_update: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(dq_hiz) |-> ($past(st) == ST_UPD_IR));

  a_r12_enable_only_shift: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_SH_IR && st != ST_SH_DR) |-> !tdo_en);

  a_r12_quiet_when_off: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);
endmodule

bind scan_tap scan_tap_sva u_sva (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_sh(ir_sh), .ir_act(ir_act),
  .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz)
);

// File: tb/tb_scan_tap.sv
module tb_scan_tap;
  localparam int BSR_W = 16;
  localparam logic [31:0] ID = 32'h1A5C_30E9;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BSR_W-1:0] pins_in = '0;
  logic tdo, tdo_en, dq_hiz;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { logic b; string tag; } exp_t;
  exp_t sb[$];

  scan_tap #(.BSR_W(BSR_W), .ID_VAL(ID)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins_in(pins_in),
    .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz)
  );

  always #4 tck = ~tck;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one scoreboard entry per falling edge with the output enabled
  always @(negedge tck) begin
    #2;
    if (!done) begin
      if (tdo_en) begin
        if (sb.size() == 0) chk(1'b1, 1'b0, "R12 (extra serial bit)");
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(tdo, e.b, e.tag);
        end
      end else if (trst_n) begin
        chk(tdo, 1'b0, "R12");
      end
    end
  end

  task automatic tick(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp,
                         input string tag);
    for (int i = 0; i < n; i++) sb.push_back('{exp[i], tag});
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_ir(input logic [2:0] op, input logic exp_hiz);
    logic old;
    old = dq_hiz;
    sb.push_back('{1'b1, "R3"}); sb.push_back('{1'b0, "R3"}); sb.push_back('{1'b0, "R3"});
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) tick(i == 2, op[i]);
    chk(dq_hiz, old, "R4 (exit1)");
    tick(1, 0);
    chk(dq_hiz, old, "R4 (update)");
    tick(0, 0);
    chk(dq_hiz, exp_hiz, "R4 (after update)");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #20;
    chk(tdo_en, 0, "R1 enable in reset");
    chk(dq_hiz, 0, "R1 hiz in reset");
    chk(tdo, 0, "R1 tdo in reset");
    @(negedge tck); trst_n = 1'b1;
    tick(0, 0);
    scan_dr(32, 64'h0, {32'h0, ID}, "R5");
    chk(tdo_en, 0, "R12 after scan");

    // bypass: first bit 0, then input delayed by one
    scan_ir(3'b111, 0);
    scan_dr(8, 64'hB2, {56'h0, 8'h64}, "R6");

    // park in Pause-DR, then five ones reach Test-Logic-Reset
    tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    scan_dr(32, 64'h0, {32'h0, ID}, "R2");

    scan_ir(3'b100, 0);
    chk(dq_hiz, 0, "R7 hiz low");
    pins_in = 16'hC35A;
    scan_dr(16, 64'h0F0F, 64'hC35A, "R7");
    chk(dq_hiz, 0, "R8 hiz after update-DR");
    pins_in = 16'h1234;
    scan_dr(16, 64'hFFFF, 64'h1234, "R8");

    scan_ir(3'b000, 1);
    chk(dq_hiz, 1, "R9 hiz");
    pins_in = 16'hA5F0;
    scan_dr(16, 64'h0, 64'hA5F0, "R9");
    chk(dq_hiz, 1, "R9 hiz held");

    scan_ir(3'b010, 1);
    pins_in = 16'h6E19;
    scan_dr(16, 64'h0, 64'h6E19, "R10");
    chk(dq_hiz, 1, "R10 hiz");

    scan_ir(3'b011, 0);
    scan_dr(4, 64'hD, 64'hA, "R11 code 011");
    scan_ir(3'b101, 0);
    scan_dr(4, 64'h6, 64'hC, "R11 code 101");
    scan_ir(3'b110, 0);
    scan_dr(4, 64'h9, 64'h2, "R11 code 110");
    chk(dq_hiz, 0, "R11 hiz");

    scan_ir(3'b010, 1);
    @(negedge tck); trst_n = 1'b0;
    #2;
    chk(dq_hiz, 0, "R1 async reset clears hiz");
    @(negedge tck); trst_n = 1'b1;
    tick(0, 0);
    scan_dr(32, 64'h0, {32'h0, ID}, "R1");

    tick(0, 0); tick(0, 0);
    chk(sb.size(), 0, "R12 all bits seen");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule